// File: doc/BRIEF.md
# Legacy System Control Port Block

This block answers byte-wide I/O-port cycles for a legacy PC-style motherboard. A host drives a 16-bit port address, a byte of write data and single-cycle read or write strobes. The block decodes a sparse set of ports. Some of them return fixed identification and configuration bytes. Others hold a few control bits, a two-byte scratch area and a speaker/timer status port. A write to certain ports fires a one-clock command pulse toward neighbouring logic: a soft reset, two non-volatile memory lock toggles and a cache invalidate.

The block watches for two kinds of misuse. One is an access to a port that is not in its map. The other is a request for a mode that the platform does not support: little-endian operation, or a non-contiguous I/O map. Either one sets a sticky error flag, which only a reset clears. Read data is registered and comes back one clock after the read strobe, with a matching valid pulse. An unmapped read returns 0xFF.

Top module: `legacy_sysctl_regs`

## Requirements
- R1: While reset is applied and after it is released, rd_data is 0x00 and every other output is 0: rd_valid, the four pulses, disk_light, sys_ctrl, spk_data_en, tmr_gate2 and err_flag.
- R2: A read strobe sampled at clock edge k makes rd_valid high for exactly the cycle after edge k, with rd_data holding the byte for that port. rd_data holds its value until the next read.
- R3: The following ports return fixed bytes: 0x0092 reads 0x00, 0x0800 reads 0xEF, 0x0802 reads 0xAD, 0x0803 reads 0xE0, 0x080C reads 0x3C, 0x0810 reads 0x39, 0x0818 reads 0x00, 0x0823 reads 0x03 and 0x0850 reads 0x01. Writes to 0x0800, 0x0802 and 0x0803 change nothing and raise no error.
- R4: A write to 0x0808 sets disk_light to bit 0 of the write data.
- R5: A write of any data to 0x0810 pulses nv_lock1_pulse, to 0x0812 pulses nv_lock2_pulse, and to 0x0814 pulses cache_inv_pulse. Each pulse is high for exactly the one cycle after the write edge, and the other pulses stay low.
- R6: A write to 0x0092 with data bit 0 set pulses soft_rst_pulse for one cycle after the write edge.
- R7: A write to 0x081C stores data bits 3:0 in sys_ctrl. A read of 0x081C returns {4'b0000, sys_ctrl}.
- R8: Ports 0x0398 and 0x0399 are two independent read/write bytes, indexed by the address minus 0x0398.
- R9: A read of port 0x0061 returns bit 5 = tmr_out2_i, bit 4 = refresh toggle, bit 1 = spk_data_en, bit 0 = tmr_gate2, and all other bits 0. A write to port 0x0061 sets spk_data_en from bit 1 and tmr_gate2 from bit 0.
- R10: The refresh bit is 0 on the first read of 0x0061 after reset and inverts after every read of 0x0061.
- R11: A write to 0x0092 with bit 1 set, or a write to 0x0850 with bit 0 clear, sets err_flag. A write of 0x01 to 0x0850 does not.
- R12: A read of any port outside the read map returns 0xFF and sets err_flag. The read map is 0x0061, 0x0092, 0x0398, 0x0399, 0x0800, 0x0802, 0x0803, 0x080C, 0x0810, 0x0818, 0x081C, 0x0823 and 0x0850. A write to any port outside the write map changes no state and sets err_flag. The write map is 0x0061, 0x0092, 0x0398, 0x0399, 0x0800, 0x0802, 0x0803, 0x0808, 0x0810, 0x0812, 0x0814, 0x081C and 0x0850.
- R13: Once set, err_flag stays set until reset, whatever accesses follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_addr | input | 16 | Port address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| tmr_out2_i | input | 1 | Output of timer channel 2, reported on the speaker port |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | High for the cycle in which rd_data answers a read |
| soft_rst_pulse | output | 1 | One-cycle soft reset request |
| nv_lock1_pulse | output | 1 | One-cycle lock toggle 1 |
| nv_lock2_pulse | output | 1 | One-cycle lock toggle 2 |
| cache_inv_pulse | output | 1 | One-cycle cache invalidate |
| disk_light | output | 1 | Hard-disk activity light state |
| sys_ctrl | output | 4 | System control bits |
| spk_data_en | output | 1 | Speaker data enable |
| tmr_gate2 | output | 1 | Gate of timer channel 2 |
| err_flag | output | 1 | Sticky error flag |

## Verification
Most of the state in this block is visible one cycle after the access that changes it. A wrong control, light or speaker bit shows at once on its output pin. A wrong scratch byte or refresh phase shows on rd_data one cycle after the next read of that port. A decode fault can make a port answer with the wrong constant, fail to return 0xFF, or set or miss err_flag. Since err_flag is sticky, such a fault shows in the cycle after the offending access and stays visible until reset. For that reason each address of a full 4096-port sweep is checked starting from a fresh reset.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int DATA_W = 8;

  // port map (16-bit I/O space)
  localparam logic [15:0] P_SPEAKER  = 16'h0061;
  localparam logic [15:0] P_CTL92    = 16'h0092;
  localparam logic [15:0] P_CPU_ID   = 16'h0800;
  localparam logic [15:0] P_BRD_FEAT = 16'h0802;
  localparam logic [15:0] P_BRD_STAT = 16'h0803;
  localparam logic [15:0] P_DISK_LED = 16'h0808;
  localparam logic [15:0] P_EQUIP    = 16'h080C;
  localparam logic [15:0] P_EXT_LCK1 = 16'h0810;
  localparam logic [15:0] P_LOCK2    = 16'h0812;
  localparam logic [15:0] P_L2_INVAL = 16'h0814;
  localparam logic [15:0] P_KEYLOCK  = 16'h0818;
  localparam logic [15:0] P_SYSCTL   = 16'h081C;
  localparam logic [15:0] P_L2_STAT  = 16'h0823;
  localparam logic [15:0] P_MAP_TYPE = 16'h0850;

  // fixed read values
  localparam logic [DATA_W-1:0] V_CPU_ID   = 8'hEF;
  localparam logic [DATA_W-1:0] V_BRD_FEAT = 8'hAD;
  localparam logic [DATA_W-1:0] V_BRD_STAT = 8'hE0;
  localparam logic [DATA_W-1:0] V_EQUIP    = 8'h3C;
  localparam logic [DATA_W-1:0] V_EXT_FEAT = 8'h39;
  localparam logic [DATA_W-1:0] V_L2_STAT  = 8'h03;
  localparam logic [DATA_W-1:0] V_MAP_TYPE = 8'h01;
  localparam logic [DATA_W-1:0] V_UNMAPPED = 8'hFF;

  // speaker port bit positions
  localparam int SPK_GATE_BIT = 0;
  localparam int SPK_EN_BIT   = 1;
  localparam int SPK_REF_BIT  = 4;
  localparam int SPK_OUT_BIT  = 5;

  // control-port-92 bits
  localparam int C92_SOFTRST_BIT = 0;
  localparam int C92_LE_BIT      = 1;
  localparam int MAP_CONTIG_BIT  = 0;

  // pulse vector positions
  localparam int PULSE_N     = 4;
  localparam int PI_SOFTRST  = 0;
  localparam int PI_LOCK1    = 1;
  localparam int PI_LOCK2    = 2;
  localparam int PI_INVAL    = 3;

  typedef enum logic [3:0] {
    RS_NONE, RS_ZERO, RS_SPK, RS_SCR, RS_CPU, RS_FEAT, RS_STAT,
    RS_EQUIP, RS_EXT, RS_CTRL, RS_L2, RS_MAP
  } rd_sel_e;

  typedef struct packed {
    logic spk;
    logic ctl92;
    logic scratch;
    logic disk_led;
    logic lock1;
    logic lock2;
    logic l2_inval;
    logic sysctl;
    logic map_type;
  } wr_hit_t;

endpackage

// File: rtl/sysctl_addr_decode.sv
module sysctl_addr_decode
  import sysctl_pkg::*;
#(
  parameter int          ADDR_W        = 16,
  parameter logic [15:0] SCRATCH_BASE  = 16'h0398,
  parameter int          SCRATCH_DEPTH = 2,
  parameter int          IDX_W         = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output rd_sel_e           rd_sel,
  output wr_hit_t           wr_hit,
  output logic [IDX_W-1:0]  scr_idx,
  output logic              wr_mapped
);

  logic [ADDR_W-1:0] scr_offs;
  logic              scr_hit;
  logic              id_hit;

  function automatic logic is_port(input logic [ADDR_W-1:0] a,
                                   input logic [15:0] p);
    return a == ADDR_W'(p);
  endfunction

  assign scr_offs = addr - ADDR_W'(SCRATCH_BASE);
  assign scr_hit  = (scr_offs < ADDR_W'(SCRATCH_DEPTH));
  assign scr_idx  = scr_offs[IDX_W-1:0];

  // read selection
  always_comb begin
    rd_sel = RS_NONE;
    if (scr_hit)                                 rd_sel = RS_SCR;
    else if (is_port(addr, P_SPEAKER))           rd_sel = RS_SPK;
    else if (is_port(addr, P_CTL92) ||
             is_port(addr, P_KEYLOCK))           rd_sel = RS_ZERO;
    else if (is_port(addr, P_CPU_ID))            rd_sel = RS_CPU;
    else if (is_port(addr, P_BRD_FEAT))          rd_sel = RS_FEAT;
    else if (is_port(addr, P_BRD_STAT))          rd_sel = RS_STAT;
    else if (is_port(addr, P_EQUIP))             rd_sel = RS_EQUIP;
    else if (is_port(addr, P_EXT_LCK1))          rd_sel = RS_EXT;
    else if (is_port(addr, P_SYSCTL))            rd_sel = RS_CTRL;
    else if (is_port(addr, P_L2_STAT))           rd_sel = RS_L2;
    else if (is_port(addr, P_MAP_TYPE))          rd_sel = RS_MAP;
  end

  // write targets
  always_comb begin
    wr_hit          = '0;
    wr_hit.scratch  = scr_hit;
    wr_hit.spk      = is_port(addr, P_SPEAKER);
    wr_hit.ctl92    = is_port(addr, P_CTL92);
    wr_hit.disk_led = is_port(addr, P_DISK_LED);
    wr_hit.lock1    = is_port(addr, P_EXT_LCK1);
    wr_hit.lock2    = is_port(addr, P_LOCK2);
    wr_hit.l2_inval = is_port(addr, P_L2_INVAL);
    wr_hit.sysctl   = is_port(addr, P_SYSCTL);
    wr_hit.map_type = is_port(addr, P_MAP_TYPE);
  end

  // identification ports accept writes silently
  assign id_hit = is_port(addr, P_CPU_ID) || is_port(addr, P_BRD_FEAT) ||
                  is_port(addr, P_BRD_STAT);

  assign wr_mapped = id_hit || (|wr_hit);

endmodule

// File: rtl/sysctl_scratch.sv
module sysctl_scratch #(
  parameter int DEPTH  = 2,
  parameter int IDX_W  = 1,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    logic              ld;
    logic [DATA_W-1:0] nxt;

    assign ld  = wr_en && (idx == IDX_W'(g));
    assign nxt = ld ? wdata : mem_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[g] <= '0;
      else        mem_q[g] <= nxt;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (idx == IDX_W'(i)) rdata = mem_q[i];
    end
  end

endmodule

// File: rtl/sysctl_pulse_gen.sv
module sysctl_pulse_gen #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] fire,
  output logic [N-1:0] pulse
);

  for (genvar g = 0; g < N; g++) begin : g_pulse
    logic p_nxt;
    assign p_nxt = fire[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse[g] <= 1'b0;
      else        pulse[g] <= p_nxt;
    end
  end

endmodule

// File: rtl/sysctl_read_mux.sv
module sysctl_read_mux
  import sysctl_pkg::*;
#(
  parameter int CTRL_W = 4
) (
  input  rd_sel_e           sel,
  input  logic [DATA_W-1:0] scr_byte,
  input  logic [DATA_W-1:0] spk_byte,
  input  logic [CTRL_W-1:0] ctrl_bits,
  output logic [DATA_W-1:0] rdata
);

  always_comb begin
    unique case (sel)
      RS_ZERO:  rdata = '0;
      RS_SPK:   rdata = spk_byte;
      RS_SCR:   rdata = scr_byte;
      RS_CPU:   rdata = V_CPU_ID;
      RS_FEAT:  rdata = V_BRD_FEAT;
      RS_STAT:  rdata = V_BRD_STAT;
      RS_EQUIP: rdata = V_EQUIP;
      RS_EXT:   rdata = V_EXT_FEAT;
      RS_CTRL:  rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_bits};
      RS_L2:    rdata = V_L2_STAT;
      RS_MAP:   rdata = V_MAP_TYPE;
      default:  rdata = V_UNMAPPED;
    endcase
  end

endmodule

// File: rtl/legacy_sysctl_regs.sv
module legacy_sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int          ADDR_W        = 16,
  parameter logic [15:0] SCRATCH_BASE  = 16'h0398,
  parameter int          SCRATCH_DEPTH = 2,
  parameter int          CTRL_W        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  input  logic              tmr_out2_i,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              soft_rst_pulse,
  output logic              nv_lock1_pulse,
  output logic              nv_lock2_pulse,
  output logic              cache_inv_pulse,
  output logic              disk_light,
  output logic [CTRL_W-1:0] sys_ctrl,
  output logic              spk_data_en,
  output logic              tmr_gate2,
  output logic              err_flag
);

  localparam int IDX_W = (SCRATCH_DEPTH > 1) ? $clog2(SCRATCH_DEPTH) : 1;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // decode
  rd_sel_e            rd_sel;
  wr_hit_t            wr_hit;
  logic [IDX_W-1:0]   scr_idx;
  logic               wr_mapped;

  sysctl_addr_decode #(
    .ADDR_W        (ADDR_W),
    .SCRATCH_BASE  (SCRATCH_BASE),
    .SCRATCH_DEPTH (SCRATCH_DEPTH),
    .IDX_W         (IDX_W)
  ) u_dec (
    .addr      (io_addr),
    .rd_sel    (rd_sel),
    .wr_hit    (wr_hit),
    .scr_idx   (scr_idx),
    .wr_mapped (wr_mapped)
  );

  // scratch bytes
  logic [DATA_W-1:0] scr_byte;

  sysctl_scratch #(
    .DEPTH  (SCRATCH_DEPTH),
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W)
  ) u_scr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (io_wr && wr_hit.scratch),
    .idx   (scr_idx),
    .wdata (io_wdata),
    .rdata (scr_byte)
  );

  // state registers
  logic              light_q,   light_d;
  logic [CTRL_W-1:0] ctrl_q,    ctrl_d;
  logic              spk_en_q,  spk_en_d;
  logic              gate_q,    gate_d;
  logic              refresh_q, refresh_d;
  logic              err_q,     err_d;
  logic [DATA_W-1:0] rdat_q,    rdat_d;
  logic              rvld_q;

  logic              wr_err;
  logic              rd_err;
  logic [DATA_W-1:0] spk_byte;
  logic [DATA_W-1:0] mux_byte;

  always_comb begin
    spk_byte               = '0;
    spk_byte[SPK_GATE_BIT] = gate_q;
    spk_byte[SPK_EN_BIT]   = spk_en_q;
    spk_byte[SPK_REF_BIT]  = refresh_q;
    spk_byte[SPK_OUT_BIT]  = tmr_out2_i;
  end

  sysctl_read_mux #(
    .CTRL_W (CTRL_W)
  ) u_mux (
    .sel       (rd_sel),
    .scr_byte  (scr_byte),
    .spk_byte  (spk_byte),
    .ctrl_bits (ctrl_q),
    .rdata     (mux_byte)
  );

  assign wr_err = io_wr && (!wr_mapped ||
                  (wr_hit.ctl92    &&  io_wdata[C92_LE_BIT]) ||
                  (wr_hit.map_type && !io_wdata[MAP_CONTIG_BIT]));
  assign rd_err = io_rd && (rd_sel == RS_NONE);

  // next state
  always_comb begin
    light_d   = light_q;
    ctrl_d    = ctrl_q;
    spk_en_d  = spk_en_q;
    gate_d    = gate_q;
    refresh_d = refresh_q;
    rdat_d    = rdat_q;
    err_d     = err_q || wr_err || rd_err;
    if (io_wr && wr_hit.disk_led) light_d = io_wdata[0];
    if (io_wr && wr_hit.sysctl)   ctrl_d  = io_wdata[CTRL_W-1:0];
    if (io_wr && wr_hit.spk) begin
      spk_en_d = io_wdata[SPK_EN_BIT];
      gate_d   = io_wdata[SPK_GATE_BIT];
    end
    if (io_rd) begin
      rdat_d = mux_byte;
      if (rd_sel == RS_SPK) refresh_d = !refresh_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      light_q   <= 1'b0;
      ctrl_q    <= '0;
      spk_en_q  <= 1'b0;
      gate_q    <= 1'b0;
      refresh_q <= 1'b0;
      err_q     <= 1'b0;
      rdat_q    <= '0;
      rvld_q    <= 1'b0;
    end else begin
      light_q   <= light_d;
      ctrl_q    <= ctrl_d;
      spk_en_q  <= spk_en_d;
      gate_q    <= gate_d;
      refresh_q <= refresh_d;
      err_q     <= err_d;
      rdat_q    <= rdat_d;
      rvld_q    <= io_rd;
    end
  end

  // command pulses
  logic [PULSE_N-1:0] fire;
  logic [PULSE_N-1:0] pulse;

  always_comb begin
    fire             = '0;
    fire[PI_SOFTRST] = io_wr && wr_hit.ctl92 && io_wdata[C92_SOFTRST_BIT];
    fire[PI_LOCK1]   = io_wr && wr_hit.lock1;
    fire[PI_LOCK2]   = io_wr && wr_hit.lock2;
    fire[PI_INVAL]   = io_wr && wr_hit.l2_inval;
  end

  sysctl_pulse_gen #(
    .N (PULSE_N)
  ) u_pulse (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .fire  (fire),
    .pulse (pulse)
  );

  assign rd_data         = rdat_q;
  assign rd_valid        = rvld_q;
  assign soft_rst_pulse  = pulse[PI_SOFTRST];
  assign nv_lock1_pulse  = pulse[PI_LOCK1];
  assign nv_lock2_pulse  = pulse[PI_LOCK2];
  assign cache_inv_pulse = pulse[PI_INVAL];
  assign disk_light      = light_q;
  assign sys_ctrl        = ctrl_q;
  assign spk_data_en     = spk_en_q;
  assign tmr_gate2       = gate_q;
  assign err_flag        = err_q;

endmodule

// File: rtl/legacy_sysctl_regs_chk.sv
module legacy_sysctl_regs_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_wdata,
  input logic [7:0]        rd_data,
  input logic              rd_valid,
  input logic              soft_rst_pulse,
  input logic              cache_inv_pulse,
  input logic              err_flag
);

  a_r2_valid_after_read: assert property (@(posedge clk) disable iff (!rst_sync_n)
    io_rd |=> rd_valid);

  a_r2_no_valid_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !io_rd |=> !rd_valid);

  a_r3_cpu_id_value: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_rd && io_addr == ADDR_W'(16'h0800)) |=> (rd_data == 8'hEF));

  a_r5_inval_fires: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_wr && io_addr == ADDR_W'(16'h0814)) |=> cache_inv_pulse);

  a_r5_inval_one_wide: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cache_inv_pulse && !(io_wr && io_addr == ADDR_W'(16'h0814))) |=> !cache_inv_pulse);

  a_r6_softrst_fires: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_wr && io_addr == ADDR_W'(16'h0092) && io_wdata[0]) |=> soft_rst_pulse);

  a_r12_hole_reads_ff: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_rd && io_addr == ADDR_W'(16'h0801)) |=> (rd_data == 8'hFF && err_flag));

  a_r13_err_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_flag |=> err_flag);

endmodule

bind legacy_sysctl_regs legacy_sysctl_regs_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk             (clk),
  .rst_sync_n      (rst_sync_n),
  .io_addr         (io_addr),
  .io_wr           (io_wr),
  .io_rd           (io_rd),
  .io_wdata        (io_wdata),
  .rd_data         (rd_data),
  .rd_valid        (rd_valid),
  .soft_rst_pulse  (soft_rst_pulse),
  .cache_inv_pulse (cache_inv_pulse),
  .err_flag        (err_flag)
);

// File: tb/legacy_sysctl_regs_tb_top.sv
module legacy_sysctl_regs_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic        tmr_out2_i = 1'b1;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic        soft_rst_pulse, nv_lock1_pulse, nv_lock2_pulse, cache_inv_pulse;
  logic        disk_light;
  logic [3:0]  sys_ctrl;
  logic        spk_data_en, tmr_gate2, err_flag;

  int vectors = 0;
  int misses  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  legacy_sysctl_regs dut_i (
    .clk (clk), .rst_n (rst_n), .io_addr (io_addr), .io_wr (io_wr),
    .io_rd (io_rd), .io_wdata (io_wdata), .tmr_out2_i (tmr_out2_i),
    .rd_data (rd_data), .rd_valid (rd_valid),
    .soft_rst_pulse (soft_rst_pulse), .nv_lock1_pulse (nv_lock1_pulse),
    .nv_lock2_pulse (nv_lock2_pulse), .cache_inv_pulse (cache_inv_pulse),
    .disk_light (disk_light), .sys_ctrl (sys_ctrl),
    .spk_data_en (spk_data_en), .tmr_gate2 (tmr_gate2), .err_flag (err_flag)
  );

  // expected read values for a freshly reset block (R3, R9, R12)
  function automatic logic [8:0] exp_read(input logic [15:0] a, input logic tmr);
    // bit 8: port is read-mapped
    case (a)
      16'h0061: return {1'b1, 2'b00, tmr, 5'b00000};
      16'h0092, 16'h0818, 16'h0398, 16'h0399, 16'h081C: return 9'h100;
      16'h0800: return 9'h1EF;
      16'h0802: return 9'h1AD;
      16'h0803: return 9'h1E0;
      16'h080C: return 9'h13C;
      16'h0810: return 9'h139;
      16'h0823: return 9'h103;
      16'h0850: return 9'h101;
      default:  return 9'h0FF;
    endcase
  endfunction

  function automatic logic wr_mapped(input logic [15:0] a);
    case (a)
      16'h0061, 16'h0092, 16'h0398, 16'h0399, 16'h0800, 16'h0802, 16'h0803,
      16'h0808, 16'h0810, 16'h0812, 16'h0814, 16'h081C, 16'h0850: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    io_wr = 1'b0;
    io_rd = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // one access; returns at the negedge after the sampling edge
  task automatic io_cyc(input logic w, input logic r,
                        input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = w; io_rd = r; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
  endtask

  task automatic pulses_quiet(input string req);
    chk(req, "soft_rst_pulse", 16'(soft_rst_pulse), 16'h0);
    chk(req, "nv_lock1_pulse", 16'(nv_lock1_pulse), 16'h0);
    chk(req, "nv_lock2_pulse", 16'(nv_lock2_pulse), 16'h0);
    chk(req, "cache_inv_pulse", 16'(cache_inv_pulse), 16'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1", "rd_data in reset", 16'(rd_data), 16'h0);
    do_reset();
    chk("R1", "rd_data", 16'(rd_data), 16'h0);
    chk("R1", "rd_valid", 16'(rd_valid), 16'h0);
    pulses_quiet("R1");
    chk("R1", "light/ctrl/spk/gate/err",
        16'({disk_light, sys_ctrl, spk_data_en, tmr_gate2, err_flag}), 16'h0);

    // R2: latency and hold
    io_cyc(1'b0, 1'b1, 16'h0803, 8'h00);
    chk("R2", "rd_valid after read", 16'(rd_valid), 16'h1);
    @(negedge clk);
    chk("R2", "rd_valid one cycle", 16'(rd_valid), 16'h0);
    chk("R2", "rd_data held", 16'(rd_data), 16'h00E0);

    // R3: ID writes ignored
    do_reset();
    io_cyc(1'b1, 1'b0, 16'h0800, 8'h00);
    io_cyc(1'b1, 1'b0, 16'h0802, 8'h55);
    io_cyc(1'b1, 1'b0, 16'h0803, 8'h11);
    chk("R3", "err after id writes", 16'(err_flag), 16'h0);
    io_cyc(1'b0, 1'b1, 16'h0800, 8'h00);
    chk("R3", "cpu id after write", 16'(rd_data), 16'h00EF);
    io_cyc(1'b0, 1'b1, 16'h0802, 8'h00);
    chk("R3", "feat after write", 16'(rd_data), 16'h00AD);

    // R4: disk light
    io_cyc(1'b1, 1'b0, 16'h0808, 8'h03);
    chk("R4", "disk_light set", 16'(disk_light), 16'h1);
    io_cyc(1'b1, 1'b0, 16'h0808, 8'hFE);
    chk("R4", "disk_light clear", 16'(disk_light), 16'h0);

    // R5: command pulses
    io_cyc(1'b1, 1'b0, 16'h0810, 8'h00);
    chk("R5", "lock1 pulse", 16'({soft_rst_pulse, nv_lock1_pulse, nv_lock2_pulse, cache_inv_pulse}), 16'h4);
    @(negedge clk);
    pulses_quiet("R5");
    io_cyc(1'b1, 1'b0, 16'h0812, 8'hA5);
    chk("R5", "lock2 pulse", 16'({soft_rst_pulse, nv_lock1_pulse, nv_lock2_pulse, cache_inv_pulse}), 16'h2);
    @(negedge clk);
    pulses_quiet("R5");
    io_cyc(1'b1, 1'b0, 16'h0814, 8'hFF);
    chk("R5", "invalidate pulse", 16'({soft_rst_pulse, nv_lock1_pulse, nv_lock2_pulse, cache_inv_pulse}), 16'h1);
    @(negedge clk);
    pulses_quiet("R5");

    // R6: soft reset
    io_cyc(1'b1, 1'b0, 16'h0092, 8'h01);
    chk("R6", "soft reset pulse", 16'(soft_rst_pulse), 16'h1);
    @(negedge clk);
    chk("R6", "soft reset one wide", 16'(soft_rst_pulse), 16'h0);
    io_cyc(1'b1, 1'b0, 16'h0092, 8'h00);
    chk("R6", "no pulse for bit0 clear", 16'(soft_rst_pulse), 16'h0);

    // R7: system control
    io_cyc(1'b1, 1'b0, 16'h081C, 8'hFA);
    chk("R7", "sys_ctrl", 16'(sys_ctrl), 16'h000A);
    io_cyc(1'b0, 1'b1, 16'h081C, 8'h00);
    chk("R7", "sys_ctrl readback", 16'(rd_data), 16'h000A);

    // R8: scratch
    io_cyc(1'b1, 1'b0, 16'h0398, 8'h5A);
    io_cyc(1'b1, 1'b0, 16'h0399, 8'hC3);
    io_cyc(1'b0, 1'b1, 16'h0398, 8'h00);
    chk("R8", "scratch 0", 16'(rd_data), 16'h005A);
    io_cyc(1'b0, 1'b1, 16'h0399, 8'h00);
    chk("R8", "scratch 1", 16'(rd_data), 16'h00C3);
    chk("R8", "err clean", 16'(err_flag), 16'h0);

    // R9, R10: speaker port
    do_reset();
    io_cyc(1'b1, 1'b0, 16'h0061, 8'h03);
    chk("R9", "en/gate", 16'({spk_data_en, tmr_gate2}), 16'h3);
    io_cyc(1'b0, 1'b1, 16'h0061, 8'h00);
    chk("R10", "first read refresh 0", 16'(rd_data), 16'h0023);
    io_cyc(1'b0, 1'b1, 16'h0061, 8'h00);
    chk("R10", "second read refresh 1", 16'(rd_data), 16'h0033);
    tmr_out2_i = 1'b0;
    io_cyc(1'b1, 1'b0, 16'h0061, 8'h02);
    io_cyc(1'b0, 1'b1, 16'h0061, 8'h00);
    chk("R9", "en only, tmr 0", 16'(rd_data), 16'h0002);
    tmr_out2_i = 1'b1;

    // R11: unsupported modes
    do_reset();
    io_cyc(1'b1, 1'b0, 16'h0850, 8'h01);
    chk("R11", "contiguous map ok", 16'(err_flag), 16'h0);
    io_cyc(1'b1, 1'b0, 16'h0850, 8'h00);
    chk("R11", "non-contiguous map", 16'(err_flag), 16'h1);
    // R13: sticky
    io_cyc(1'b0, 1'b1, 16'h0800, 8'h00);
    io_cyc(1'b1, 1'b0, 16'h081C, 8'h01);
    chk("R13", "err sticky", 16'(err_flag), 16'h1);
    do_reset();
    chk("R13", "err cleared by reset", 16'(err_flag), 16'h0);
    io_cyc(1'b1, 1'b0, 16'h0092, 8'h02);
    chk("R11", "little endian request", 16'(err_flag), 16'h1);

    // R12: dropped write to hole
    do_reset();
    io_cyc(1'b1, 1'b0, 16'h081D, 8'h0F);
    chk("R12", "hole write err", 16'(err_flag), 16'h1);
    chk("R12", "hole write no state", 16'(sys_ctrl), 16'h0);

    // R3, R12: read sweep over 0x000..0xFFF
    for (int a = 0; a < 4096; a++) begin
      logic [8:0] e;
      e = exp_read(16'(a), tmr_out2_i);
      do_reset();
      io_cyc(1'b0, 1'b1, 16'(a), 8'h00);
      chk("R12", $sformatf("read data @%0h", a), 16'(rd_data), 16'(e[7:0]));
      chk("R12", $sformatf("read err @%0h", a), 16'(err_flag), 16'(!e[8]));
    end

    // R12: write sweep, data 0x01 keeps mode ports legal
    for (int a = 0; a < 4096; a++) begin
      do_reset();
      io_cyc(1'b1, 1'b0, 16'(a), 8'h01);
      chk("R12", $sformatf("write err @%0h", a), 16'(err_flag),
          16'(!wr_mapped(16'(a))));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule